// File: doc/BRIEF.md
# Rate-Limited Line Violation Status Counter

This block watches a strobe from a line decoder that pulses once for each bipolar code violation. It keeps three status bits that a host samples at its leisure. The host infers how many violations occurred by noting how often each bit has flipped. Two fine bits flip on every 64th and every 128th violation and have no rate limit. The coarse bit flips once per 256 violations. However, it is never allowed to flip sooner than a minimum refresh interval after its previous flip.

The refresh interval is measured in ticks of a 1 ms time base and defaults to 96 ticks. Sometimes 256 violations pile up before the interval has elapsed. In that case the coarse bit waits for the interval to end, and any violation that arrives during the wait is thrown away. When the violations arrive more slowly than the interval, the coarse bit flips as soon as the 256th one is counted. The fine bits come from a separate tally that counts every violation, whether or not the coarse path is waiting.

Top module: `line_viol_status`

## Requirements
- R1: While reset is high, and immediately after it is released, all three status outputs read 0. Reset clears every counter, and the refresh interval begins again from the reset.
- R2: `fine_o` inverts once for every 64 violations. Specifically, it inverts on the clock edge that samples the 64th, 128th, 192nd, ... violation strobe since reset, and the new value is visible after that edge.
- R3: `mid_o` inverts once for every 128 violations, on the clock edge that samples the 128th, 256th, ... violation strobe since reset.
- R4: The tally that drives `fine_o` and `mid_o` counts every violation strobe. This includes strobes that arrive while the coarse bit is waiting out its interval. The tally wraps freely and is never held.
- R5: The coarse bit `coarse_o` inverts on the clock edge that samples the 256th counted violation, provided that at least REFRESH_MS tick strobes have been sampled since the last coarse inversion (or since reset). Ticks beyond REFRESH_MS are not accumulated.
- R6: If the 256th counted violation arrives before REFRESH_MS ticks have been sampled, `coarse_o` holds its value. It then inverts on the clock edge that follows the edge which sampled the REFRESH_MS-th tick.
- R7: Violation strobes sampled while the coarse bit is waiting are discarded. After every coarse inversion, both the coarse violation count and the tick count restart from zero. A tick sampled on the inversion edge is not counted.
- R8: Two changes of `coarse_o` are always separated by at least REFRESH_MS sampled ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| viol_i | input | 1 | One-cycle strobe per detected bipolar violation |
| tick_i | input | 1 | One-cycle strobe per millisecond of the time base |
| coarse_o | output | 1 | Status bit inverting per 256 violations, rate limited |
| mid_o | output | 1 | Status bit inverting per 128 violations |
| fine_o | output | 1 | Status bit inverting per 64 violations |

## Verification
The bench targets the edge where the 256th violation lands just before the interval expires, and the edge where it lands just after. A design that compared the interval with an off-by-one bound would flip the coarse bit one tick too early or too late. The bench also floods the block with violations during the wait. A design that kept counting those violations would flip the coarse bit again well before 256 fresh violations had arrived, while one that froze the free tally would let the fine bits fall behind. Long mixed phases then alternate between dense and sparse violation traffic. These phases show whether the tick count restarts at each flip and saturates instead of wrapping: a timer that wraps would open the window at the wrong time.

// File: rtl/lvs_pkg.sv
package lvs_pkg;

    typedef enum logic {
        GATE_COUNT = 1'b0,
        GATE_HOLD  = 1'b1
    } gate_state_e;

    typedef struct packed {
        logic coarse;
        logic mid;
        logic fine;
    } viol_status_t;

    function automatic int unsigned span_width(input int unsigned limit);
        return (limit < 1) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/lvs_tally.sv
module lvs_tally #(
    parameter int unsigned TALLY_W = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       viol_i,
    output logic [1:0] flags_o
);
    localparam int unsigned LOW_TAP = TALLY_W - 2;

    logic [TALLY_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (viol_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    for (genvar k = 0; k < 2; k++) begin : g_tap
        localparam int unsigned TAP = LOW_TAP + k;
        logic flag_q;
        logic wrap_w;

        assign wrap_w = viol_i && (&cnt_q[TAP-1:0]);

        always_ff @(posedge clk) begin
            if (rst) begin
                flag_q <= 1'b0;
            end else if (wrap_w) begin
                flag_q <= ~flag_q;
            end
        end

        assign flags_o[k] = flag_q;
    end

endmodule

// File: rtl/lvs_refresh_timer.sv
module lvs_refresh_timer #(
    parameter int unsigned REFRESH_MS = 96
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic restart_i,
    output logic done_o
);
    localparam int unsigned TW = lvs_pkg::span_width(REFRESH_MS);
    localparam logic [TW-1:0] LIMIT = TW'(REFRESH_MS);

    logic [TW-1:0] ms_q;

    always_ff @(posedge clk) begin
        if (rst || restart_i) begin
            ms_q <= '0;
        end else if (tick_i && (ms_q != LIMIT)) begin
            ms_q <= ms_q + 1'b1;
        end
    end

    assign done_o = (ms_q == LIMIT);

endmodule

// File: rtl/lvs_coarse_gate.sv
module lvs_coarse_gate
    import lvs_pkg::*;
#(
    parameter int unsigned TALLY_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic viol_i,
    input  logic window_open_i,
    output logic fire_o,
    output logic hold_o,
    output logic coarse_o
);
    gate_state_e        state_q;
    logic [TALLY_W-1:0] acc_q;
    logic               coarse_q;
    logic               full_hit;
    logic               fire;

    always_comb begin
        full_hit = (state_q == GATE_COUNT) && viol_i && (&acc_q);
        fire     = (full_hit || (state_q == GATE_HOLD)) && window_open_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= GATE_COUNT;
            acc_q    <= '0;
            coarse_q <= 1'b0;
        end else if (fire) begin
            coarse_q <= ~coarse_q;
            acc_q    <= '0;
            state_q  <= GATE_COUNT;
        end else if (full_hit) begin
            state_q  <= GATE_HOLD;
            acc_q    <= '0;
        end else if ((state_q == GATE_COUNT) && viol_i) begin
            acc_q    <= acc_q + 1'b1;
        end
    end

    assign fire_o   = fire;
    assign hold_o   = (state_q == GATE_HOLD);
    assign coarse_o = coarse_q;

endmodule

// File: rtl/line_viol_status.sv
module line_viol_status
    import lvs_pkg::*;
#(
    parameter int unsigned TALLY_W    = 8,
    parameter int unsigned REFRESH_MS = 96
) (
    input  logic clk,
    input  logic rst,
    input  logic viol_i,
    input  logic tick_i,
    output logic coarse_o,
    output logic mid_o,
    output logic fine_o
);
    logic [1:0]   tally_flags;
    logic         fire_w;
    logic         hold_w;
    logic         win_open_w;
    logic         coarse_w;
    viol_status_t status;

    lvs_tally #(.TALLY_W(TALLY_W)) u_tally (
        .clk     (clk),
        .rst     (rst),
        .viol_i  (viol_i),
        .flags_o (tally_flags)
    );

    lvs_refresh_timer #(.REFRESH_MS(REFRESH_MS)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick_i),
        .restart_i (fire_w),
        .done_o    (win_open_w)
    );

    lvs_coarse_gate #(.TALLY_W(TALLY_W)) u_gate (
        .clk           (clk),
        .rst           (rst),
        .viol_i        (viol_i),
        .window_open_i (win_open_w),
        .fire_o        (fire_w),
        .hold_o        (hold_w),
        .coarse_o      (coarse_w)
    );

    always_comb begin
        status.coarse = coarse_w;
        status.mid    = tally_flags[1];
        status.fine   = tally_flags[0];
    end

    assign coarse_o = status.coarse;
    assign mid_o    = status.mid;
    assign fine_o   = status.fine;

endmodule

// File: rtl/lvs_checker.sv
module lvs_checker #(
    parameter int unsigned TALLY_W    = 8,
    parameter int unsigned REFRESH_MS = 96
) (
    input logic clk,
    input logic rst,
    input logic viol_i,
    input logic tick_i,
    input logic coarse_o,
    input logic mid_o,
    input logic fine_o,
    input logic hold_w,
    input logic win_open_w
);
    localparam int unsigned TW = lvs_pkg::span_width(REFRESH_MS);
    localparam logic [TW-1:0] LIMIT = TW'(REFRESH_MS);

    logic [TW-1:0] ms_seen;
    logic          coarse_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            ms_seen     <= '0;
            coarse_prev <= 1'b0;
        end else begin
            coarse_prev <= coarse_o;
            if (coarse_o != coarse_prev) begin
                ms_seen <= tick_i ? TW'(1) : '0;
            end else if (tick_i && (ms_seen != LIMIT)) begin
                ms_seen <= ms_seen + 1'b1;
            end
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        $past(rst) |-> (!coarse_o && !mid_o && !fine_o)); // R1

    AST_FINE_NEEDS_VIOL: assert property (@(posedge clk) disable iff (rst)
        !$stable(fine_o) |-> $past(viol_i)); // R2

    AST_MID_NEEDS_VIOL: assert property (@(posedge clk) disable iff (rst)
        !$stable(mid_o) |-> $past(viol_i)); // R3

    AST_MID_WITH_FINE: assert property (@(posedge clk) disable iff (rst)
        !$stable(mid_o) |-> !$stable(fine_o)); // R4

    AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (hold_w && win_open_w) |=> (!hold_w && !$stable(coarse_o))); // R6

    AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (rst)
        (hold_w && !win_open_w) |=> (hold_w && $stable(coarse_o))); // R7

    AST_COARSE_SPACING: assert property (@(posedge clk) disable iff (rst)
        !$stable(coarse_o) |-> ($past(ms_seen) >= LIMIT)); // R8

    AST_COARSE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        !$stable(coarse_o) |-> ($past(viol_i) || $past(hold_w))); // R5

endmodule

bind line_viol_status lvs_checker #(
    .TALLY_W    (TALLY_W),
    .REFRESH_MS (REFRESH_MS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .viol_i     (viol_i),
    .tick_i     (tick_i),
    .coarse_o   (coarse_o),
    .mid_o      (mid_o),
    .fine_o     (fine_o),
    .hold_w     (hold_w),
    .win_open_w (win_open_w)
);

// File: tb/line_viol_status_test.sv
`timescale 1ns/1ps
module line_viol_status_test;

    localparam int REFRESH = 96;
    localparam int COARSE  = 256;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic viol_i = 1'b0;
    logic tick_i = 1'b0;
    logic coarse_o, mid_o, fine_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // requirement-level model
    int m_total, m_acc, m_tmr;
    bit m_hold, m_coarse, m_mid, m_fine;
    int gap_ticks;
    logic [31:0] lfsr = 32'h1ACE_5EED;

    always #5 clk = ~clk;

    line_viol_status #(.TALLY_W(8), .REFRESH_MS(REFRESH)) uut (
        .clk      (clk),
        .rst      (rst),
        .viol_i   (viol_i),
        .tick_i   (tick_i),
        .coarse_o (coarse_o),
        .mid_o    (mid_o),
        .fine_o   (fine_o)
    );

    task automatic check(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_total = 0; m_acc = 0; m_tmr = 0;
        m_hold = 0; m_coarse = 0; m_mid = 0; m_fine = 0;
        gap_ticks = 0;
    endtask

    task automatic model_step(input bit v, input bit t);
        bit fire;
        fire = ((!m_hold && v && m_acc == COARSE - 1) || m_hold) && (m_tmr >= REFRESH);
        if (v) begin
            m_total++;
            if (m_total % 64 == 0)  m_fine = ~m_fine;
            if (m_total % 128 == 0) m_mid  = ~m_mid;
        end
        if (fire) begin
            m_coarse = ~m_coarse;
            m_acc = 0; m_hold = 0; m_tmr = 0;
        end else begin
            if (!m_hold && v) begin
                if (m_acc == COARSE - 1) begin m_hold = 1; m_acc = 0; end
                else m_acc++;
            end
            if (t && m_tmr < REFRESH) m_tmr++;
        end
    endtask

    task automatic step(input bit v, input bit t);
        logic prev_coarse;
        prev_coarse = coarse_o;
        viol_i = v;
        tick_i = t;
        model_step(v, t);
        @(posedge clk);
        #1;
        if (coarse_o !== prev_coarse) begin
            checks++;
            if (gap_ticks < REFRESH) begin
                failures++;
                $display("FAIL R8: got spacing %0d expected >= %0d", gap_ticks, REFRESH);
            end
            gap_ticks = 0;
        end else if (t) begin
            gap_ticks++;
        end
        check(fine_o, m_fine, "R2 fine");
        check(mid_o, m_mid, "R3 mid");
        check(coarse_o, m_coarse, "R5 coarse");
        viol_i = 1'b0;
        tick_i = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        viol_i = 1'b0;
        tick_i = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check(coarse_o, 1'b0, "R1 coarse");
        check(mid_o, 1'b0, "R1 mid");
        check(fine_o, 1'b0, "R1 fine");
        rst = 1'b0;
        model_reset();
    endtask

    initial begin
        model_reset();
        do_reset();

        // R2/R3: exact boundaries of the free tally, no ticks
        for (int i = 0; i < 63; i++) step(1, 0);
        check(fine_o, 1'b0, "R2 before 64th");
        step(1, 0);
        check(fine_o, 1'b1, "R2 at 64th");
        for (int i = 0; i < 63; i++) step(1, 0);
        check(mid_o, 1'b0, "R3 before 128th");
        step(1, 0);
        check(mid_o, 1'b1, "R3 at 128th");

        // R6: 256th counted long before the interval ends
        for (int i = 0; i < 128; i++) step(1, 0);
        check(coarse_o, 1'b0, "R6 waiting");
        // R4/R7: flood during the wait; fine bits still move
        for (int i = 0; i < 200; i++) step(1, (i % 4) == 0);
        check(fine_o, m_fine, "R4 tally during hold");
        check(coarse_o, 1'b0, "R7 no early flip");
        while (m_tmr < REFRESH - 1) step(0, 1);
        step(0, 1);
        check(coarse_o, 1'b0, "R6 one cycle after last tick");
        step(0, 0);
        check(coarse_o, 1'b1, "R6 released");

        // R7: count restarted; 255 fresh plus a full interval is not enough
        for (int i = 0; i < 255; i++) step(1, 1);
        check(coarse_o, 1'b1, "R7 discarded strobes not counted");
        step(1, 0);
        check(coarse_o, 1'b0, "R5 prompt flip on 256th");

        // R5: interval ends exactly one tick before the 256th
        for (int i = 0; i < REFRESH; i++) step(0, 1);
        for (int i = 0; i < 255; i++) step(1, 0);
        step(1, 1);
        check(coarse_o, 1'b1, "R5 boundary flip");

        // R1: reset in the middle of activity
        for (int i = 0; i < 300; i++) step(1, (i % 3) == 0);
        do_reset();

        // mixed phases, dense and sparse violation traffic
        for (int ph = 0; ph < 16; ph++) begin
            for (int i = 0; i < 2500; i++) begin
                bit v, t;
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                if (ph % 2 == 0) begin
                    v = (lfsr[2:0] != 3'd0);
                    t = (lfsr[10:5] == 6'd0);
                end else begin
                    v = lfsr[3];
                    t = (lfsr[9:8] == 2'd0);
                end
                step(v, t);
            end
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1_900_000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule